// File: doc/BRIEF.md
# Codec Control Serial Master

This block drives a three-line control link to an audio codec. The lines are a mode line, a serial clock and a serial data line. A host places a 2-bit transfer type and one or two payload bytes on the inputs, then pulses a start strobe for one cycle. The master first sends an address byte while the mode line marks the address phase. It then raises the mode line and shifts out the payload bytes. A single-byte payload programs one of the directly addressed codec registers. A two-byte payload programs an extended register: the host builds both bytes, and the master sends them in order.

Every interval on the link is a whole number of system clock cycles, derived from nanosecond minimums and the clock period at elaboration. The intervals are clock high, clock low, data setup, data hold, mode setup, mode hold and the halt gap between bytes. The host watches `busy_o` and receives a one-cycle `done_o` pulse once the last halt gap has elapsed.

Top module: `codec_ctl_master`

## Requirements
- R1: After reset and whenever idle, `busy_o` and `done_o` are 0, `cb_clk_o` and `cb_mode_o` are 1, and after reset `cb_data_o` is 0.
- R2: The first byte of every transfer carries the device address 5 in bits 7:2 and `kind_i` in bits 1:0, and `cb_mode_o` is 0 at each of its rising clock edges.
- R3: Each byte is sent least significant bit first. The data line changes only while the clock is high or at a falling clock edge, and it is read at each rising edge.
- R4: After the address byte, `byte_a_i` is sent, then `byte_b_i` only when `ext_i` is 1. `cb_mode_o` is 1 at every rising edge of these bytes.
- R5: Inside a byte, each clock low period lasts exactly LO cycles and each clock high period exactly HI cycles. LO is the larger of ceil(clock-low/period) and ceil(data-setup/period). HI is the larger of ceil(clock-high/period) and ceil(data-hold/period).
- R6: Data is stable for at least ceil(data-setup/period) cycles before every rising edge. It does not change within ceil(data-hold/period) cycles after a rising edge.
- R7: The mode line changes only while the clock stays high. Each change comes at least ceil(mode-hold/period) cycles after the last rising edge, and at least ceil(mode-setup/period) cycles before the next falling edge.
- R8: From the last rising edge of one byte to the first falling edge of the next byte there are exactly HI + MH + HT + SU cycles. MH and HT are the rounded mode-hold and halt times. SU is the larger of the rounded mode-setup and data-setup times.
- R9: `done_o` is high for exactly one cycle, HI + MH + HT cycles after the final rising edge of the transfer, with `busy_o` low in that cycle. There is one pulse per accepted start.
- R10: `busy_o` rises in the cycle after an accepted start and falls only in the `done_o` cycle. A start strobe seen while busy changes neither the transfer in progress nor the count of transfers.
- R11: A start strobe present in the same cycle as `done_o` is accepted and begins a new transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| kind_i | input | 2 | Transfer type placed in the address byte |
| ext_i | input | 1 | 1 sends two payload bytes, 0 sends one |
| byte_a_i | input | 8 | First payload byte |
| byte_b_i | input | 8 | Second payload byte (used when `ext_i` is 1) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cb_mode_o | output | 1 | Mode line: 0 address phase, 1 data phase |
| cb_clk_o | output | 1 | Serial clock, idles high |
| cb_data_o | output | 1 | Serial data |

## Verification
The completion pulse and a new start strobe can occur in the same cycle, because `done_o` is raised in the first idle cycle. The bench provokes this by asserting start in the very sample where it sees `done_o`. It judges the result by `busy_o` rising one cycle later and by the follow-on frame matching its own expected bytes and timing. It also fires stray starts with different inputs in the middle of a transfer and confirms the frame in flight and the completion count are unaffected.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_HALT
  } seq_state_t;

  // Round a nanosecond minimum up to clock cycles, never below one cycle.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/codec_ctl_timer.sv
module codec_ctl_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)             cnt_d = load_val_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // Interval counter steps down by one per cycle unless reloaded (R5)
  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/codec_ctl_frame.sv
module codec_ctl_frame #(
  parameter int DEV_ADDR = 5,
  parameter int KIND_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic              ext_i,
  input  logic [7:0]        byte_a_i,
  input  logic [7:0]        byte_b_i,
  input  logic [1:0]        sel_i,
  output logic [7:0]        byte_o,
  output logic              last_o
);

  localparam int DEV_W = 8 - KIND_W;

  logic [KIND_W-1:0] kind_q;
  logic              ext_q;
  logic [7:0]        a_q, b_q;
  logic [7:0]        addr_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      ext_q  <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
    end else if (accept_i) begin
      kind_q <= kind_i;
      ext_q  <= ext_i;
      a_q    <= byte_a_i;
      b_q    <= byte_b_i;
    end
  end

  assign addr_byte = {DEV_W'(DEV_ADDR), kind_q};

  always_comb begin
    case (sel_i)
      2'd0:    byte_o = addr_byte;
      2'd1:    byte_o = a_q;
      default: byte_o = b_q;
    endcase
  end

  assign last_o = ext_q ? (sel_i == 2'd2) : (sel_i == 2'd1);

  // Captured request only moves on an accepted start (R10)
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> ($stable(kind_q) && $stable(ext_q) && $stable(a_q) && $stable(b_q)));

endmodule

// File: rtl/codec_ctl_seq.sv
module codec_ctl_seq
  import codec_ctl_pkg::*;
#(
  parameter int CW     = 4,
  parameter int SU_C   = 1,
  parameter int LO_C   = 1,
  parameter int HI_C   = 1,
  parameter int MH_C   = 1,
  parameter int HALT_C = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [7:0]    cur_byte_i,
  input  logic          last_byte_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic [1:0]    sel_o,
  output logic          accept_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          cb_mode_o,
  output logic          cb_clk_o,
  output logic          cb_data_o
);

  seq_state_t    state_q, state_d;
  logic [2:0]    bit_q, bit_d;
  logic [1:0]    sel_q, sel_d;
  logic          clk_q, clk_d;
  logic          mode_q, mode_d;
  logic          data_q, data_d;
  logic          done_q, done_d;
  logic          load;
  logic [CW-1:0] load_val;

  assign accept_o = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    sel_d    = sel_q;
    clk_d    = clk_q;
    mode_d   = mode_q;
    data_d   = data_q;
    done_d   = 1'b0;
    load     = 1'b0;
    load_val = '0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_SETUP;
          sel_d    = 2'd0;
          bit_d    = 3'd0;
          mode_d   = 1'b0;
          load     = 1'b1;
          load_val = CW'(SU_C - 1);
        end
      end
      ST_SETUP: begin
        data_d = cur_byte_i[0];
        if (tmr_zero_i) begin
          state_d  = ST_LOW;
          clk_d    = 1'b0;
          load     = 1'b1;
          load_val = CW'(LO_C - 1);
        end
      end
      ST_LOW: begin
        if (tmr_zero_i) begin
          state_d  = ST_HIGH;
          clk_d    = 1'b1;
          load     = 1'b1;
          load_val = CW'(HI_C - 1);
        end
      end
      ST_HIGH: begin
        if (tmr_zero_i) begin
          load = 1'b1;
          if (bit_q == 3'd7) begin
            state_d  = ST_HOLD;
            load_val = CW'(MH_C - 1);
          end else begin
            state_d  = ST_LOW;
            bit_d    = bit_q + 3'd1;
            data_d   = cur_byte_i[bit_q + 3'd1];
            clk_d    = 1'b0;
            load_val = CW'(LO_C - 1);
          end
        end
      end
      ST_HOLD: begin
        if (tmr_zero_i) begin
          state_d  = ST_HALT;
          load     = 1'b1;
          load_val = CW'(HALT_C - 1);
        end
      end
      ST_HALT: begin
        if (tmr_zero_i) begin
          if (last_byte_i) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d  = ST_SETUP;
            sel_d    = sel_q + 2'd1;
            bit_d    = 3'd0;
            mode_d   = 1'b1;
            load     = 1'b1;
            load_val = CW'(SU_C - 1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sel_q   <= '0;
      clk_q   <= 1'b1;
      mode_q  <= 1'b1;
      data_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sel_q   <= sel_d;
      clk_q   <= clk_d;
      mode_q  <= mode_d;
      data_q  <= data_d;
      done_q  <= done_d;
    end
  end

  assign tmr_load_o = load;
  assign tmr_val_o  = load_val;
  assign sel_o      = sel_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign cb_mode_o  = mode_q;
  assign cb_clk_o   = clk_q;
  assign cb_data_o  = data_q;

  // Idle lines rest high (R1)
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cb_clk_o && cb_mode_o));

  // Data never moves across a low clock period (R3)
  p_data_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_data_o != $past(cb_data_o)) |-> (cb_clk_o || $past(cb_clk_o)));

  // Mode only changes while the clock stays high (R7)
  p_mode_clk_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_mode_o != $past(cb_mode_o)) |-> (cb_clk_o && $past(cb_clk_o)));

  // Completion is a single-cycle pulse outside busy (R9)
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

// File: rtl/codec_ctl_master.sv
module codec_ctl_master
  import codec_ctl_pkg::*;
#(
  parameter int CLK_PERIOD_NS  = 10,
  parameter int T_CLK_HIGH_NS  = 250,
  parameter int T_CLK_LOW_NS   = 250,
  parameter int T_DSETUP_NS    = 190,
  parameter int T_DHOLD_NS     = 30,
  parameter int T_MSETUP_NS    = 190,
  parameter int T_MHOLD_NS     = 190,
  parameter int T_HALT_NS      = 190,
  parameter int DEV_ADDR       = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] kind_i,
  input  logic       ext_i,
  input  logic [7:0] byte_a_i,
  input  logic [7:0] byte_b_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       cb_mode_o,
  output logic       cb_clk_o,
  output logic       cb_data_o
);

  localparam int HI_C   = imax(ns_to_cyc(T_CLK_HIGH_NS, CLK_PERIOD_NS),
                               ns_to_cyc(T_DHOLD_NS, CLK_PERIOD_NS));
  localparam int LO_C   = imax(ns_to_cyc(T_CLK_LOW_NS, CLK_PERIOD_NS),
                               ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS));
  localparam int SU_C   = imax(ns_to_cyc(T_MSETUP_NS, CLK_PERIOD_NS),
                               ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS));
  localparam int MH_C   = ns_to_cyc(T_MHOLD_NS, CLK_PERIOD_NS);
  localparam int HALT_C = ns_to_cyc(T_HALT_NS, CLK_PERIOD_NS);
  localparam int MAX_C  = imax(imax(HI_C, LO_C), imax(SU_C, imax(MH_C, HALT_C)));
  localparam int CW     = imax($clog2(MAX_C + 1), 1);

  logic          accept;
  logic [1:0]    sel;
  logic [7:0]    cur_byte;
  logic          last_byte;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;

  codec_ctl_frame #(
    .DEV_ADDR (DEV_ADDR),
    .KIND_W   (2)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .kind_i   (kind_i),
    .ext_i    (ext_i),
    .byte_a_i (byte_a_i),
    .byte_b_i (byte_b_i),
    .sel_i    (sel),
    .byte_o   (cur_byte),
    .last_o   (last_byte)
  );

  codec_ctl_timer #(
    .CW (CW)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  codec_ctl_seq #(
    .CW     (CW),
    .SU_C   (SU_C),
    .LO_C   (LO_C),
    .HI_C   (HI_C),
    .MH_C   (MH_C),
    .HALT_C (HALT_C)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cur_byte_i  (cur_byte),
    .last_byte_i (last_byte),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .sel_o       (sel),
    .accept_o    (accept),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .cb_mode_o   (cb_mode_o),
    .cb_clk_o    (cb_clk_o),
    .cb_data_o   (cb_data_o)
  );

endmodule

// File: tb/codec_ctl_master_tb.sv
`timescale 1ns/1ps
module codec_ctl_master_tb;

  localparam int CLK_PERIOD = 50;
  // Interval counts derived from the nanosecond minimums at this period
  localparam int C_HI  = 5;  // max(ceil(250/50), ceil(30/50))
  localparam int C_LO  = 5;  // max(ceil(250/50), ceil(190/50))
  localparam int C_SU  = 4;  // max(ceil(190/50), ceil(190/50))
  localparam int C_MH  = 4;
  localparam int C_HT  = 4;
  localparam int C_DSU = 4;
  localparam int C_DH  = 1;
  localparam int C_MSU = 4;

  logic clk, rst_n, start_i, ext_i;
  logic [1:0] kind_i;
  logic [7:0] byte_a_i, byte_b_i;
  logic busy_o, done_o, cb_mode_o, cb_clk_o, cb_data_o;

  codec_ctl_master #(.CLK_PERIOD_NS(CLK_PERIOD)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
    .ext_i(ext_i), .byte_a_i(byte_a_i), .byte_b_i(byte_b_i),
    .busy_o(busy_o), .done_o(done_o), .cb_mode_o(cb_mode_o),
    .cb_clk_o(cb_clk_o), .cb_data_o(cb_data_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  int launches = 0, dones = 0;
  int cyc = 0;
  bit finished = 0;

  logic [1:0] exp_kind;  logic exp_ext;  logic [7:0] exp_a, exp_b;
  logic [1:0] cur_kind;  logic cur_ext;  logic [7:0] cur_a, cur_b;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int idx, input logic [1:0] k,
                                          input logic [7:0] a, input logic [7:0] b);
    if (idx == 0) return {6'd5, k};
    if (idx == 1) return a;
    return b;
  endfunction

  // ---------------- monitor ----------------
  logic pclk, pmode, pdata, pbusy, pdone;
  int last_rise, last_fall, last_dchg, last_mchg, nb;
  bit mode_pending;
  logic [23:0] cap_d, cap_m;

  always @(negedge clk) begin
    if (!rst_n) begin
      pclk <= 1'b1; pmode <= 1'b1; pdata <= 1'b0; pbusy <= 1'b0; pdone <= 1'b0;
      last_rise = -1000; last_fall = -1000; last_dchg = -1000; last_mchg = -1000;
      nb = 0; mode_pending = 0;
    end else if (!finished) begin
      cyc++;
      if (busy_o && !pbusy) begin
        cur_kind = exp_kind; cur_ext = exp_ext; cur_a = exp_a; cur_b = exp_b;
        nb = 0; cap_d = '0; cap_m = '0;
      end
      if (!busy_o && pbusy)
        chk(done_o == 1'b1, "R10 busy falls only with done", done_o, 1);
      if (cb_data_o != pdata) begin
        if (!cb_clk_o && !pclk) chk(0, "R3 data moved while clock low", 1, 0);
        if (cb_clk_o && pclk)
          chk(cyc - last_rise >= C_DH, "R6 data hold", cyc - last_rise, C_DH);
        last_dchg = cyc;
      end
      if (cb_mode_o != pmode) begin
        chk(cb_clk_o && pclk, "R7 mode change with clock high", cb_clk_o, 1);
        chk(cyc - last_rise >= C_MH, "R7 mode hold", cyc - last_rise, C_MH);
        last_mchg = cyc; mode_pending = 1;
      end
      if (cb_clk_o && !pclk) begin
        chk(cyc - last_fall == C_LO, "R5 clock low width", cyc - last_fall, C_LO);
        chk(cyc - last_dchg >= C_DSU, "R6 data setup", cyc - last_dchg, C_DSU);
        if (nb < 24) begin cap_d[nb] = cb_data_o; cap_m[nb] = cb_mode_o; end
        nb++;
        last_rise = cyc;
      end
      if (!cb_clk_o && pclk) begin
        if (nb % 8 != 0)
          chk(cyc - last_rise == C_HI, "R5 clock high width", cyc - last_rise, C_HI);
        else if (nb > 0)
          chk(cyc - last_rise == C_HI + C_MH + C_HT + C_SU, "R8 byte gap",
              cyc - last_rise, C_HI + C_MH + C_HT + C_SU);
        if (mode_pending)
          chk(cyc - last_mchg >= C_MSU, "R7 mode setup", cyc - last_mchg, C_MSU);
        mode_pending = 0;
        last_fall = cyc;
      end
      if (done_o) begin
        dones++;
        chk(!pdone, "R9 done one cycle", pdone, 0);
        chk(!busy_o, "R9 busy low with done", busy_o, 0);
        chk(cyc - last_rise == C_HI + C_MH + C_HT, "R9 done delay",
            cyc - last_rise, C_HI + C_MH + C_HT);
        chk(nb == (cur_ext ? 24 : 16), "R4 byte count", nb, cur_ext ? 24 : 16);
        chk(cap_d[7:0] == exp_byte(0, cur_kind, cur_a, cur_b), "R2 R3 address byte LSB first",
            cap_d[7:0], exp_byte(0, cur_kind, cur_a, cur_b));
        chk(cap_m[7:0] == 8'h00, "R2 mode low in address", cap_m[7:0], 0);
        chk(cap_d[15:8] == cur_a, "R4 first payload byte", cap_d[15:8], cur_a);
        chk(cap_m[15:8] == 8'hFF, "R4 mode high in payload", cap_m[15:8], 8'hFF);
        if (cur_ext) begin
          chk(cap_d[23:16] == cur_b, "R4 second payload byte", cap_d[23:16], cur_b);
          chk(cap_m[23:16] == 8'hFF, "R4 mode high in second byte", cap_m[23:16], 8'hFF);
        end
      end
      pclk <= cb_clk_o; pmode <= cb_mode_o; pdata <= cb_data_o;
      pbusy <= busy_o; pdone <= done_o;
    end
  end

  // ---------------- driver ----------------
  // Called at a negedge: drives the request and pulses start for one cycle.
  task automatic launch(input logic [1:0] k, input logic e, input logic [7:0] a,
                        input logic [7:0] b);
    exp_kind = k; exp_ext = e; exp_a = a; exp_b = b;
    kind_i = k; ext_i = e; byte_a_i = a; byte_b_i = b;
    start_i = 1'b1;
    launches++;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
  endtask

  // Waits until done is seen at a negedge; optionally fires a stray start mid-frame.
  task automatic wait_done(input bit poke);
    int n;
    n = 0;
    while (!done_o && n < 5000) begin
      if (poke && n == 30) begin
        kind_i = ~kind_i; ext_i = ~ext_i; byte_a_i = ~byte_a_i; byte_b_i = 8'h3C;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n++;
      end else begin
        @(negedge clk);
        n++;
      end
    end
    if (n >= 5000) chk(0, "R9 transfer never completed", 0, 1);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h0C0DE5);
    rst_n = 1'b0; start_i = 1'b0; kind_i = '0; ext_i = 1'b0;
    byte_a_i = '0; byte_b_i = '0;
    exp_kind = '0; exp_ext = 1'b0; exp_a = '0; exp_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
    chk(done_o == 1'b0, "R1 reset done", done_o, 0);
    chk(cb_clk_o == 1'b1, "R1 reset clock high", cb_clk_o, 1);
    chk(cb_mode_o == 1'b1, "R1 reset mode high", cb_mode_o, 1);
    chk(cb_data_o == 1'b0, "R1 reset data low", cb_data_o, 0);

    // Directed corners: every kind, both lengths, extreme bytes
    launch(2'd0, 1'b0, 8'h00, 8'h00); wait_done(0);
    repeat (2) @(negedge clk);
    launch(2'd1, 1'b1, 8'hFF, 8'hFF); wait_done(0);
    repeat (2) @(negedge clk);
    launch(2'd2, 1'b1, 8'hC5, 8'hE9); wait_done(1);   // R10 stray start mid-frame
    repeat (2) @(negedge clk);
    launch(2'd3, 1'b0, 8'hA5, 8'h5A); wait_done(0);
    // R11: start in the same cycle as done
    launch(2'd2, 1'b0, 8'h81, 8'h00); wait_done(0);
    launch(2'd0, 1'b1, 8'hC3, 8'hE1); wait_done(1);
    repeat (3) @(negedge clk);
    chk(cb_clk_o && cb_mode_o && !busy_o, "R1 idle lines", {cb_clk_o, cb_mode_o, busy_o}, 6);

    for (int i = 0; i < 24; i++) begin
      logic [31:0] r;
      r = $urandom;
      launch(r[1:0], r[2], r[15:8], r[23:16]);
      wait_done(r[24]);
      if (!r[25]) repeat (1 + r[28:26]) @(negedge clk);  // else back-to-back (R11)
    end

    repeat (4) @(negedge clk);
    chk(dones == launches, "R9 R10 one done per accepted start", dones, launches);
    chk(!busy_o && cb_clk_o && cb_mode_o, "R1 final idle", busy_o, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", dones, launches);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule